// File: doc/BRIEF.md
# Page-Write Collector with Self-Timed Program Cycle

This block sits behind a serial-memory bus front end and turns one write command into a single program cycle on a 2048-byte array. The front end signals the start of a write command with a begin strobe and the 11-bit starting address. It then delivers each data byte with a byte strobe, and finally signals the bus STOP. Bytes are gathered in a 16-entry page buffer, and each entry has its own valid bit. Only the low four address bits advance per byte, so a long command wraps inside its 16-byte row and overwrites earlier entries.

On a STOP that closes a command with at least one buffered byte, the block enters the program cycle. It raises `busy` for exactly `PROG_CYCLES` clock cycles. During the first 16 of those cycles it steps through the row offsets in ascending order and writes only the offsets it received. While `busy` is high, every strobe is ignored. The array resets to all ones (FFh) and has a combinational read port, which the read side of the front end uses.

The states are IDLE (no command open), COLLECT (a command is open and bytes are being buffered) and PROGRAM (the array is being written and the timer is running). The transitions are:
- IDLE goes to COLLECT on begin.
- COLLECT goes back to COLLECT on a new begin, which restarts the command.
- COLLECT goes to PROGRAM on a STOP with data pending.
- COLLECT goes to IDLE on a STOP with nothing pending.
- PROGRAM goes to IDLE when the timer reaches its last count.

Top module: `pgw_engine`

## Requirements
- R1: Every array write made by a program cycle lands at address {row, offset}, where row is bits 10..4 of the address given with the most recent accepted begin strobe.
- R2: The first accepted byte is buffered at offset = start address bits 3..0, and each later byte goes to the next offset modulo 16. A byte that reaches an already-filled offset replaces it, and the last value wins.
- R3: `busy` rises only in the cycle after a clock edge at which `stop_evt` was sampled in COLLECT with at least one byte pending.
- R4: `busy` stays high for exactly `PROG_CYCLES` cycles. While it is high, `wr_begin`, `byte_vld` and `stop_evt` have no effect: they neither open a command, nor buffer data, nor lengthen the cycle.
- R5: A byte presented with `wr_protect` high is not buffered and does not advance the offset. A command whose bytes were all protected starts no program cycle.
- R6: After reset every array location reads FFh, `busy` is low and `arr_we` is low.
- R7: Only offsets that received a byte are written, and all other locations of the row keep their previous contents.
- R8: A STOP that closes a command with no buffered byte leaves `busy` low and writes nothing.
- R9: A begin strobe while a command is open discards all bytes buffered so far and restarts at the new address.
- R10: A byte and a STOP sampled at the same edge are both honoured: the byte is buffered and included in the program cycle that the STOP starts.
- R11: A byte strobe with no command open (IDLE) is ignored.
- R12: `arr_we` is high only while `busy` is high. The writes come one per received offset in ascending offset order, within the first 16 busy cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_begin | input | 1 | Start of a write command; loads row and offset |
| wr_addr | input | 11 | Starting byte address, sampled with `wr_begin` |
| byte_vld | input | 1 | One data byte is present on `byte_data` |
| byte_data | input | 8 | Data byte |
| wr_protect | input | 1 | High: current byte is refused |
| stop_evt | input | 1 | Bus STOP seen |
| busy | output | 1 | Program cycle in progress |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 11 | Array write address |
| arr_wdata | output | 8 | Array write data |
| rd_addr | input | 11 | Array read address |
| rd_data | output | 8 | Array read data (combinational) |

## Verification
The last data byte and the STOP can arrive at the same clock edge, so buffering and the decision to start programming fall in one cycle. The bench drives `byte_vld` and `stop_evt` in the same cycle. It then expects `busy` in the next cycle, sees the byte's write from the scoreboard queue, and reads the byte back at its offset. A second collision comes from strobes driven in the middle of the program cycle. These are judged by an unchanged busy length, the absence of unexpected array writes, and the fact that no command is left open afterwards.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_PROGRAM = 2'd2
    } pgw_state_e;
endpackage

// File: rtl/pgw_array.sv
module pgw_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
    parameter int OFF_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic [OFF_W-1:0]  start_off_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic [OFF_W-1:0]  rd_off_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_vld_o,
    output logic              any_vld_o
);
    localparam int PAGE = 1 << OFF_W;

    logic [DATA_W-1:0] cell_q [PAGE];
    logic [PAGE-1:0]   vld_q;
    logic [OFF_W-1:0]  ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            ptr_q <= '0;
        end else if (clr_i) begin
            vld_q <= '0;
            ptr_q <= start_off_i;
        end else if (push_i) begin
            vld_q[ptr_q] <= 1'b1;
            ptr_q        <= ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_i && !clr_i) cell_q[ptr_q] <= push_data_i;
    end

    assign rd_data_o = cell_q[rd_off_i];
    assign rd_vld_o  = vld_q[rd_off_i];
    assign any_vld_o = |vld_q;
endmodule

// File: rtl/pgw_prog_timer.sv
module pgw_prog_timer #(
    parameter int CYCLES = 50000,
    parameter int CNT_W  = $clog2(CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (run_i && !last_o)  cnt_q <= cnt_q + 1'b1;
        else                        cnt_q <= '0;
    end

    assign cnt_o  = cnt_q;
    assign last_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/pgw_engine.sv
module pgw_engine
    import pgw_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int OFF_W       = 4,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_begin,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              wr_protect,
    input  logic              stop_evt,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int ROW_W = ADDR_W - OFF_W;
    localparam int PAGE  = 1 << OFF_W;
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0] PAGE_CNT = CNT_W'(PAGE);

    pgw_state_e        state_q, state_d;
    logic [ROW_W-1:0]  row_q;
    logic              open_cmd, take_byte, pending;
    logic              buf_any, cell_vld;
    logic [DATA_W-1:0] cell_data;
    logic [CNT_W-1:0]  tcnt;
    logic              tlast;
    logic              in_commit;

    assign open_cmd  = wr_begin && (state_q != ST_PROGRAM);
    assign take_byte = (state_q == ST_COLLECT) && byte_vld && !wr_protect && !wr_begin;
    assign pending   = buf_any || take_byte;

    pgw_page_buf #(.OFF_W(OFF_W), .DATA_W(DATA_W)) page_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (open_cmd),
        .start_off_i (wr_addr[OFF_W-1:0]),
        .push_i      (take_byte),
        .push_data_i (byte_data),
        .rd_off_i    (tcnt[OFF_W-1:0]),
        .rd_data_o   (cell_data),
        .rd_vld_o    (cell_vld),
        .any_vld_o   (buf_any)
    );

    pgw_prog_timer #(.CYCLES(PROG_CYCLES), .CNT_W(CNT_W)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q == ST_PROGRAM),
        .cnt_o  (tcnt),
        .last_o (tlast)
    );

    pgw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (arr_we),
        .waddr_i (arr_addr),
        .wdata_i (arr_wdata),
        .raddr_i (rd_addr),
        .rdata_o (rd_data)
    );

    // Next-state decision: begin outranks STOP; byte and STOP combine.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (wr_begin) state_d = ST_COLLECT;
            ST_COLLECT: begin
                if (wr_begin)      state_d = ST_COLLECT;
                else if (stop_evt) state_d = pending ? ST_PROGRAM : ST_IDLE;
            end
            ST_PROGRAM: if (tlast) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        row_q <= '0;
        else if (open_cmd) row_q <= wr_addr[ADDR_W-1:OFF_W];
    end

    // Outputs: commit one offset per cycle during the first PAGE busy cycles.
    always_comb begin
        busy      = (state_q == ST_PROGRAM);
        in_commit = busy && (tcnt < PAGE_CNT);
        arr_we    = in_commit && cell_vld;
        arr_addr  = {row_q, tcnt[OFF_W-1:0]};
        arr_wdata = cell_data;
    end
endmodule

// File: rtl/pgw_engine_chk.sv
module pgw_engine_chk #(
    parameter int ADDR_W      = 11,
    parameter int OFF_W       = 4,
    parameter int PROG_CYCLES = 50000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_begin,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              stop_evt,
    input logic              busy,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr
);
    localparam int ROW_W = ADDR_W - OFF_W;

    int unsigned      busy_run;
    logic [ROW_W-1:0] seen_row;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 seen_row <= '0;
        else if (wr_begin && !busy) seen_row <= wr_addr[ADDR_W-1:OFF_W];
    end

    p_row_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (arr_addr[ADDR_W-1:OFF_W] == seen_row));

    p_start_on_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt));

    p_busy_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_run == PROG_CYCLES - 1) |=> !busy);

    p_busy_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_run < PROG_CYCLES - 1) |=> busy);

    p_we_in_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);
endmodule

bind pgw_engine pgw_engine_chk #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .PROG_CYCLES(PROG_CYCLES)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_begin (wr_begin),
    .wr_addr  (wr_addr),
    .stop_evt (stop_evt),
    .busy     (busy),
    .arr_we   (arr_we),
    .arr_addr (arr_addr)
);

// File: tb/pgw_engine_tb_top.sv
module pgw_engine_tb_top;
    localparam int PC = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_begin = 1'b0;
    logic [10:0] wr_addr = '0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        wr_protect = 1'b0;
    logic        stop_evt = 1'b0;
    logic        busy, arr_we;
    logic [10:0] arr_addr;
    logic [7:0]  arr_wdata;
    logic [10:0] rd_addr = '0;
    logic [7:0]  rd_data;

    always #5 clk = ~clk;

    pgw_engine #(.PROG_CYCLES(PC)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_begin(wr_begin), .wr_addr(wr_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .wr_protect(wr_protect),
        .stop_evt(stop_evt), .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    typedef struct { logic [10:0] a; logic [7:0] d; } wr_item_t;

    int          n_tests = 0;
    int          n_fail  = 0;
    wr_item_t    sbq[$];
    logic [7:0]  exp_mem [2048];
    logic        m_open = 1'b0;
    logic [6:0]  m_row = '0;
    logic [3:0]  m_off = '0;
    logic [7:0]  m_buf [16];
    logic [15:0] m_vld = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops expected array writes and compares them.
    always @(negedge clk) begin
        if (rst_n && arr_we) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R12", "unexpected array write addr", int'(arr_addr), 0);
            end else begin
                wr_item_t it;
                it = sbq.pop_front();
                chk(arr_addr == it.a, "R1", "write address", int'(arr_addr), int'(it.a));
                chk(arr_wdata == it.d, "R7", "write data", int'(arr_wdata), int'(it.d));
            end
        end
    end

    task automatic do_begin(input logic [10:0] a);
        @(negedge clk);
        wr_begin = 1'b1; wr_addr = a;
        m_open = 1'b1; m_row = a[10:4]; m_off = a[3:0]; m_vld = '0;
        @(negedge clk);
        wr_begin = 1'b0;
    endtask

    task automatic model_byte(input logic [7:0] d, input logic wp);
        if (m_open && !wp) begin
            m_buf[m_off] = d; m_vld[m_off] = 1'b1; m_off = m_off + 4'd1;
        end
    endtask

    task automatic do_byte(input logic [7:0] d, input logic wp);
        @(negedge clk);
        byte_vld = 1'b1; byte_data = d; wr_protect = wp;
        model_byte(d, wp);
        @(negedge clk);
        byte_vld = 1'b0; wr_protect = 1'b0;
    endtask

    // STOP, optionally with a byte in the same cycle and a disturbance mid-cycle.
    task automatic do_stop(input string req, input bit with_byte, input logic [7:0] d,
                           input bit disturb);
        bit pend;
        int n;
        @(negedge clk);
        stop_evt = 1'b1;
        if (with_byte) begin
            byte_vld = 1'b1; byte_data = d; wr_protect = 1'b0;
            model_byte(d, 1'b0);
        end
        pend = m_open && (m_vld != 0);
        if (pend) begin
            for (int o = 0; o < 16; o++) begin
                if (m_vld[o]) begin
                    wr_item_t it;
                    it.a = {m_row, 4'(o)}; it.d = m_buf[o];
                    sbq.push_back(it);
                    exp_mem[it.a] = it.d;
                end
            end
        end
        m_open = 1'b0;
        @(negedge clk);
        stop_evt = 1'b0; byte_vld = 1'b0;
        chk(busy == pend, req, "busy after STOP", int'(busy), int'(pend));
        if (pend) begin
            n = 0;
            while (busy && n < PC + 10) begin
                n++;
                if (disturb && n == 20) begin
                    wr_begin = 1'b1; wr_addr = 11'h070; byte_vld = 1'b1;
                    byte_data = 8'h99; stop_evt = 1'b1;
                end else begin
                    wr_begin = 1'b0; byte_vld = 1'b0; stop_evt = 1'b0;
                end
                @(negedge clk);
            end
            wr_begin = 1'b0; byte_vld = 1'b0; stop_evt = 1'b0;
            chk(n == PC, "R4", "busy length", n, PC);
            chk(sbq.size() == 0, "R12", "pending expected writes", sbq.size(), 0);
        end else begin
            @(negedge clk);
            chk(busy == 1'b0, req, "busy stays low", int'(busy), 0);
        end
    endtask

    task automatic rd_chk(input logic [10:0] a, input string req);
        @(negedge clk);
        rd_addr = a;
        #1;
        chk(rd_data == exp_mem[a], req, $sformatf("read @%0h", a),
            int'(rd_data), int'(exp_mem[a]));
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2048; i++) exp_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6: reset state
        chk(busy == 1'b0, "R6", "busy after reset", int'(busy), 0);
        chk(arr_we == 1'b0, "R6", "arr_we after reset", int'(arr_we), 0);
        rd_chk(11'h000, "R6"); rd_chk(11'h7FF, "R6"); rd_chk(11'h35A, "R6");

        // Single byte; neighbours untouched (R7, R3)
        do_begin(11'h123); do_byte(8'hA5, 1'b0);
        do_stop("R3", 1'b0, 8'h00, 1'b0);
        rd_chk(11'h123, "R7"); rd_chk(11'h124, "R7"); rd_chk(11'h122, "R7");

        // Wrap inside the row (R2, R1)
        do_begin(11'h2FC);
        for (int k = 0; k < 6; k++) do_byte(8'(8'h30 + k), 1'b0);
        do_stop("R2", 1'b0, 8'h00, 1'b0);
        rd_chk(11'h2FC, "R2"); rd_chk(11'h2FF, "R2"); rd_chk(11'h2F0, "R2");
        rd_chk(11'h2F1, "R2"); rd_chk(11'h2F2, "R7"); rd_chk(11'h300, "R1");

        // 18 bytes: last two overwrite the first two (R2)
        do_begin(11'h40E);
        for (int k = 0; k < 18; k++) do_byte(8'(8'h10 + k), 1'b0);
        do_stop("R2", 1'b0, 8'h00, 1'b0);
        rd_chk(11'h40E, "R2"); rd_chk(11'h40F, "R2"); rd_chk(11'h405, "R2");

        // Protected byte skipped, offset not advanced (R5)
        do_begin(11'h500);
        do_byte(8'h11, 1'b0); do_byte(8'h22, 1'b1); do_byte(8'h33, 1'b0);
        do_stop("R5", 1'b0, 8'h00, 1'b0);
        rd_chk(11'h500, "R5"); rd_chk(11'h501, "R5"); rd_chk(11'h502, "R5");
        do_begin(11'h600); do_byte(8'h44, 1'b1);
        do_stop("R5", 1'b0, 8'h00, 1'b0);
        rd_chk(11'h600, "R5");

        // STOP with no data (R8)
        do_begin(11'h700);
        do_stop("R8", 1'b0, 8'h00, 1'b0);
        rd_chk(11'h700, "R8");

        // Restart discards buffered bytes (R9)
        do_begin(11'h710); do_byte(8'h01, 1'b0); do_byte(8'h02, 1'b0);
        do_begin(11'h720); do_byte(8'h09, 1'b0);
        do_stop("R9", 1'b0, 8'h00, 1'b0);
        rd_chk(11'h710, "R9"); rd_chk(11'h711, "R9"); rd_chk(11'h720, "R9");

        // Byte with no command open (R11)
        do_byte(8'h77, 1'b0);
        do_stop("R11", 1'b0, 8'h00, 1'b0);
        rd_chk(11'h721, "R11");

        // Byte and STOP in one cycle (R10)
        do_begin(11'h050); do_byte(8'h01, 1'b0);
        do_stop("R10", 1'b1, 8'h02, 1'b0);
        rd_chk(11'h050, "R10"); rd_chk(11'h051, "R10");

        // Strobes during busy ignored (R4)
        do_begin(11'h060); do_byte(8'h66, 1'b0);
        do_stop("R4", 1'b0, 8'h00, 1'b1);
        do_byte(8'h55, 1'b0);
        do_stop("R4", 1'b0, 8'h00, 1'b0);
        rd_chk(11'h060, "R4"); rd_chk(11'h070, "R4"); rd_chk(11'h061, "R4");

        repeat (3) @(negedge clk);
        chk(sbq.size() == 0, "R12", "leftover expected writes", sbq.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule